// File: doc/BRIEF.md
# Interleaved Flash Command Formatter

This block turns a one-byte flash command and a command offset into the bus address and bus data word that a host drives onto a parallel NOR flash array. In the array, one or more identical devices sit side by side on a shared data bus. The caller supplies several configuration values: the native width of one device in bytes, the number of devices placed side by side (the interleave), the bus width in bytes, and the byte order of each device lane. From these the block derives the width that each device actually presents on the bus, which is called the lane width.

The bus address is the offset scaled by the device width and the interleave. For the unlock offset whose low byte is 0xAA, one extra low address bit is set when devices run narrower than their native width. The data word carries the command once in every device lane. A second, independent path reads back a bus-wide status word and folds it into one lane-wide status value by OR-ing every lane together, so that a flag raised by any device is seen.

Configuration inputs are expected to be quasi-static. An unsupported combination raises an error flag and forces the outputs to zero. When the parameter `REG_OUT` is 1, which is the default, the address, data, error and valid outputs pass through one register stage. The status fold is always combinational.

Top module: `flash_cmd_fmt`

## Requirements
- R1: When no compatibility adjustment applies, `bus_addr` equals `cmd_ofs × dev_bytes × ilv_cnt`, truncated to `ADDR_W` bits.
- R2: When `dev_bytes × ilv_cnt > bus_bytes` and `cmd_ofs[7:0] == 0xAA`, the value `(dev_bytes/2) × ilv_cnt` is ORed into the scaled address.
- R3: A configuration is legal only when all of the following hold:
  - `bus_bytes` is in {1,2,4,8};
  - `ilv_cnt` is in {1,2,4,8} and `ilv_cnt ≤ bus_bytes`;
  - `dev_bytes` is in {1,2,4};
  - the lane width `bus_bytes/ilv_cnt` is in {1,2,4}.

  Otherwise `cfg_err` is 1, and `bus_addr`, `bus_data` and `stat_merged` are all zero.
- R4: With little-endian lanes (`big_end = 0`), lane k occupies bytes k·lane .. k·lane+lane−1 of `bus_data`, where byte j is bits [8j+7:8j]. The command byte sits in byte k·lane for every k below `ilv_cnt`.
- R5: With big-endian lanes (`big_end = 1`), the command byte sits in the top byte of each lane, which is byte k·lane+lane−1.
- R6: Every other byte of `bus_data` is zero. This includes every byte at or above `bus_bytes`.
- R7: For each i below the lane width, byte i of the folded status is the OR of status byte k·lane+i over all k below `ilv_cnt`. Bytes of `stat_merged` at or above the lane width are zero.
- R8: With `big_end = 1`, the folded lane bytes are reversed within the lane before output, so folded byte i appears at byte lane−1−i.
- R9: With `REG_OUT = 1`, `bus_addr`, `bus_data`, `cfg_err` and `out_valid` appear one clock after their inputs, and `out_valid` follows `req_valid` with that same lag. Reset clears all four outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Command request strobe |
| cmd_byte | input | 8 | Command value |
| cmd_ofs | input | OFS_W | Command offset in device words |
| dev_bytes | input | CFG_W | Native device width in bytes |
| ilv_cnt | input | CFG_W | Devices side by side |
| bus_bytes | input | CFG_W | Bus width in bytes |
| big_end | input | 1 | Lane byte order, 1 = big-endian |
| stat_word | input | 8·BUS_MAX_BYTES | Bus-wide status read word |
| bus_addr | output | ADDR_W | Bus address to drive |
| bus_data | output | 8·BUS_MAX_BYTES | Replicated command word |
| out_valid | output | 1 | Address and data valid |
| cfg_err | output | 1 | Unsupported configuration |
| stat_merged | output | 32 | Folded lane-wide status |

## Verification
The bench sweeps every bus width, every interleave count (including the illegal count 3), every device width, and both byte orders. Offsets are chosen so that some have 0xAA in the low byte and some do not.

Several faults show up directly in this sweep:
- A formatter that ignores the compatibility rule, or applies it to offsets such as 0x55, gives an address that is off by a few low units.
- A formatter that places the command at the wrong end of a lane, or writes beyond the bus width, corrupts specific bytes of the data word.
- A fold that skips a lane, or forgets the byte reversal, loses status bits that only one device raised.

Illegal configurations must yield zeros together with the error flag, rather than a partially formed word.

// File: rtl/fcf_pkg.sv
package fcf_pkg;
    // Lane byte order selector
    typedef enum logic {
        LANE_LE = 1'b0,
        LANE_BE = 1'b1
    } lane_order_e;
endpackage

// File: rtl/fcf_cfg_dec.sv
module fcf_cfg_dec #(
    parameter int BUS_MAX_BYTES = 8,
    parameter int ILV_MAX       = 8,
    parameter int CFG_W         = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] dev_bytes,
    input  logic [CFG_W-1:0] ilv_cnt,
    input  logic [CFG_W-1:0] bus_bytes,
    output logic [CFG_W-1:0] lane_bytes,
    output logic             legal
);
    logic [1:0] ilv_lg;
    logic       ilv_ok, bus_ok, dev_ok, lane_ok;

    always_comb begin
        ilv_ok = 1'b1;
        ilv_lg = 2'd0;
        case (ilv_cnt)
            CFG_W'(1): ilv_lg = 2'd0;
            CFG_W'(2): ilv_lg = 2'd1;
            CFG_W'(4): ilv_lg = 2'd2;
            CFG_W'(8): ilv_lg = 2'd3;
            default:   ilv_ok = 1'b0;
        endcase
        if (int'(ilv_cnt) > ILV_MAX) ilv_ok = 1'b0;

        bus_ok = (bus_bytes == CFG_W'(1) || bus_bytes == CFG_W'(2) ||
                  bus_bytes == CFG_W'(4) || bus_bytes == CFG_W'(8)) &&
                 (int'(bus_bytes) <= BUS_MAX_BYTES);
        dev_ok = (dev_bytes == CFG_W'(1) || dev_bytes == CFG_W'(2) ||
                  dev_bytes == CFG_W'(4));

        lane_bytes = bus_bytes >> ilv_lg;
        lane_ok = (bus_bytes >= ilv_cnt) &&
                  (lane_bytes == CFG_W'(1) || lane_bytes == CFG_W'(2) ||
                   lane_bytes == CFG_W'(4));
        legal = ilv_ok && bus_ok && dev_ok && lane_ok;
    end

    // R3
    legal_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        legal |-> (int'(lane_bytes) * int'(ilv_cnt) == int'(bus_bytes)));
endmodule

// File: rtl/fcf_addr_gen.sv
module fcf_addr_gen #(
    parameter int OFS_W  = 16,
    parameter int ADDR_W = 32,
    parameter int CFG_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OFS_W-1:0]  cmd_ofs,
    input  logic [CFG_W-1:0]  dev_bytes,
    input  logic [CFG_W-1:0]  ilv_cnt,
    input  logic [CFG_W-1:0]  bus_bytes,
    output logic [ADDR_W-1:0] addr
);
    localparam logic [7:0] UNLOCK_LO = 8'hAA;

    logic [ADDR_W-1:0] scaled, compat_bit;
    logic              narrow;

    always_comb begin
        scaled     = ADDR_W'(cmd_ofs) * ADDR_W'(dev_bytes) * ADDR_W'(ilv_cnt);
        narrow     = (int'(dev_bytes) * int'(ilv_cnt)) > int'(bus_bytes);
        compat_bit = ADDR_W'(dev_bytes >> 1) * ADDR_W'(ilv_cnt);
        addr       = scaled;
        if (narrow && cmd_ofs[7:0] == UNLOCK_LO) addr = scaled | compat_bit;
    end

    // R1
    zero_ofs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ofs == '0) |-> (addr == '0));
endmodule

// File: rtl/fcf_lane_rep.sv
module fcf_lane_rep #(
    parameter int BUS_MAX_BYTES = 8,
    parameter int CFG_W         = 4
) (
    input  logic [7:0]                 cmd_byte,
    input  logic [CFG_W-1:0]           lane_bytes,
    input  logic [CFG_W-1:0]           bus_bytes,
    input  logic                       big_end,
    output logic [8*BUS_MAX_BYTES-1:0] data
);
    logic [CFG_W-1:0] pos;

    assign pos = big_end ? lane_bytes - CFG_W'(1) : '0;

    for (genvar b = 0; b < BUS_MAX_BYTES; b++) begin : g_byte
        always_comb begin
            if (CFG_W'(b) < bus_bytes &&
                (CFG_W'(b) & (lane_bytes - CFG_W'(1))) == pos)
                data[8*b +: 8] = cmd_byte;
            else
                data[8*b +: 8] = 8'h00;
        end
    end
endmodule

// File: rtl/fcf_stat_fold.sv
module fcf_stat_fold #(
    parameter int BUS_MAX_BYTES = 8,
    parameter int ILV_MAX       = 8,
    parameter int CFG_W         = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [8*BUS_MAX_BYTES-1:0] stat_word,
    input  logic [CFG_W-1:0]           lane_bytes,
    input  logic [CFG_W-1:0]           ilv_cnt,
    input  logic                       big_end,
    output logic [31:0]                folded
);
    logic [3:0][7:0] acc;

    always_comb begin
        acc    = '0;
        folded = '0;
        for (int i = 0; i < 4; i++) begin
            for (int k = 0; k < ILV_MAX; k++) begin
                if (k < int'(ilv_cnt) && i < int'(lane_bytes) &&
                    (k * int'(lane_bytes) + i) < BUS_MAX_BYTES)
                    acc[i] = acc[i] | stat_word[8*(k*int'(lane_bytes)+i) +: 8];
            end
        end
        for (int i = 0; i < 4; i++) begin
            if (i < int'(lane_bytes)) begin
                if (big_end) folded[8*(int'(lane_bytes)-1-i) +: 8] = acc[i];
                else         folded[8*i +: 8] = acc[i];
            end
        end
    end

    // R7
    zero_fold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_word == '0) |-> (folded == '0));
endmodule

// File: rtl/flash_cmd_fmt.sv
module flash_cmd_fmt #(
    parameter int BUS_MAX_BYTES = 8,
    parameter int ILV_MAX       = 8,
    parameter int OFS_W         = 16,
    parameter int ADDR_W        = 32,
    parameter bit REG_OUT       = 1'b1,
    parameter int CFG_W         = $clog2(BUS_MAX_BYTES) + 1,
    parameter int DATA_W        = 8 * BUS_MAX_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [7:0]        cmd_byte,
    input  logic [OFS_W-1:0]  cmd_ofs,
    input  logic [CFG_W-1:0]  dev_bytes,
    input  logic [CFG_W-1:0]  ilv_cnt,
    input  logic [CFG_W-1:0]  bus_bytes,
    input  logic              big_end,
    input  logic [DATA_W-1:0] stat_word,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_data,
    output logic              out_valid,
    output logic              cfg_err,
    output logic [31:0]       stat_merged
);
    import fcf_pkg::*;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              vld;
        logic              err;
    } out_t;

    logic [CFG_W-1:0]  lane_bytes;
    logic              legal;
    logic [ADDR_W-1:0] addr_raw;
    logic [DATA_W-1:0] data_raw;
    logic [31:0]       fold_raw;
    lane_order_e       order;
    out_t              out_d, out_q;

    assign order = lane_order_e'(big_end);

    fcf_cfg_dec #(.BUS_MAX_BYTES(BUS_MAX_BYTES), .ILV_MAX(ILV_MAX), .CFG_W(CFG_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .dev_bytes(dev_bytes), .ilv_cnt(ilv_cnt),
        .bus_bytes(bus_bytes), .lane_bytes(lane_bytes), .legal(legal));

    fcf_addr_gen #(.OFS_W(OFS_W), .ADDR_W(ADDR_W), .CFG_W(CFG_W)) u_addr (
        .clk(clk), .rst_n(rst_n), .cmd_ofs(cmd_ofs), .dev_bytes(dev_bytes),
        .ilv_cnt(ilv_cnt), .bus_bytes(bus_bytes), .addr(addr_raw));

    fcf_lane_rep #(.BUS_MAX_BYTES(BUS_MAX_BYTES), .CFG_W(CFG_W)) u_rep (
        .cmd_byte(cmd_byte), .lane_bytes(lane_bytes), .bus_bytes(bus_bytes),
        .big_end(order == LANE_BE), .data(data_raw));

    fcf_stat_fold #(.BUS_MAX_BYTES(BUS_MAX_BYTES), .ILV_MAX(ILV_MAX), .CFG_W(CFG_W)) u_fold (
        .clk(clk), .rst_n(rst_n), .stat_word(stat_word), .lane_bytes(lane_bytes),
        .ilv_cnt(ilv_cnt), .big_end(order == LANE_BE), .folded(fold_raw));

    always_comb begin
        out_d.vld  = req_valid;
        out_d.err  = !legal;
        out_d.addr = legal ? addr_raw : '0;
        out_d.data = legal ? data_raw : '0;
    end

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) out_q <= '0;
            else        out_q <= out_d;
        end

        // R9
        valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
            req_valid |=> out_valid);
        // R9
        valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !req_valid |=> !out_valid);
    end else begin : g_comb
        assign out_q = out_d;
    end

    assign bus_addr    = out_q.addr;
    assign bus_data    = out_q.data;
    assign out_valid   = out_q.vld;
    assign cfg_err     = out_q.err;
    assign stat_merged = legal ? fold_raw : '0;

    // R3
    err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (bus_addr == '0 && bus_data == '0));
endmodule

// File: tb/flash_cmd_fmt_tb.sv
module flash_cmd_fmt_tb;
    localparam int CFG_W = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [7:0]  cmd_byte = '0;
    logic [15:0] cmd_ofs = '0;
    logic [3:0]  dev_bytes = 4'd1, ilv_cnt = 4'd1, bus_bytes = 4'd1;
    logic        big_end = 1'b0;
    logic [63:0] stat_word = '0;
    logic [31:0] bus_addr;
    logic [63:0] bus_data;
    logic        out_valid, cfg_err;
    logic [31:0] stat_merged;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    flash_cmd_fmt u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .cmd_byte(cmd_byte),
        .cmd_ofs(cmd_ofs), .dev_bytes(dev_bytes), .ilv_cnt(ilv_cnt),
        .bus_bytes(bus_bytes), .big_end(big_end), .stat_word(stat_word),
        .bus_addr(bus_addr), .bus_data(bus_data), .out_valid(out_valid),
        .cfg_err(cfg_err), .stat_merged(stat_merged));

    always #2.5 clk = ~clk;

    function automatic bit is_legal(int bw, int il, int dw);
        bit p_bus = (bw == 1 || bw == 2 || bw == 4 || bw == 8);
        bit p_il  = (il == 1 || il == 2 || il == 4 || il == 8);
        bit p_dev = (dw == 1 || dw == 2 || dw == 4);
        if (!(p_bus && p_il && p_dev) || il > bw) return 1'b0;
        return (bw / il == 1 || bw / il == 2 || bw / il == 4);
    endfunction

    function automatic logic [31:0] exp_addr(int ofs, int bw, int il, int dw);
        logic [31:0] a = 32'(ofs * dw * il);
        if (dw * il > bw && (ofs & 'hFF) == 'hAA) a = a | 32'((dw / 2) * il);
        return a;
    endfunction

    function automatic logic [63:0] exp_data(logic [7:0] c, int bw, int il, bit be);
        logic [63:0] d = '0;
        int ln = bw / il;
        for (int k = 0; k < il; k++) d[8*(k*ln + (be ? ln-1 : 0)) +: 8] = c;
        return d;
    endfunction

    function automatic logic [31:0] exp_stat(logic [63:0] s, int bw, int il, bit be);
        logic [31:0] r = '0;
        int ln = bw / il;
        for (int i = 0; i < ln; i++) begin
            logic [7:0] b = '0;
            for (int k = 0; k < il; k++) b = b | s[8*(k*ln+i) +: 8];
            r[8*(be ? ln-1-i : i) +: 8] = b;
        end
        return r;
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    initial begin
        #1000000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int bus_set[5] = '{1, 2, 4, 8, 3};
        int ilv_set[5] = '{1, 2, 4, 8, 3};
        int ofs_set[5] = '{'h55, 'hAA, 'h2AA, 'h5555, 'h1AA};
        repeat (3) @(negedge clk);
        // R9 reset state
        check("R9 reset valid", 64'(out_valid), 64'd0);
        check("R9 reset data", bus_data, 64'd0);
        check("R9 reset addr", 64'(bus_addr), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int bi = 0; bi < 5; bi++)
          for (int ii = 0; ii < 5; ii++)
            for (int dw = 1; dw <= 5; dw++)
              for (int be = 0; be < 2; be++)
                for (int oi = 0; oi < 5; oi++) begin
                    bit lg;
                    bus_bytes = 4'(bus_set[bi]);
                    ilv_cnt   = 4'(ilv_set[ii]);
                    dev_bytes = 4'(dw);
                    big_end   = be[0];
                    cmd_ofs   = 16'(ofs_set[oi]);
                    cmd_byte  = 8'(8'h98 ^ (bi * 37 + ii * 11 + oi * 5 + be));
                    stat_word = {$urandom, $urandom};
                    req_valid = 1'b1;
                    lg = is_legal(bus_set[bi], ilv_set[ii], dw);
                    @(posedge clk);
                    @(negedge clk);
                    check("R3 cfg_err", 64'(cfg_err), 64'(!lg));
                    check("R9 out_valid", 64'(out_valid), 64'd1);
                    if (lg) begin
                        // R1 R2 address
                        check((((dw*ilv_set[ii]) > bus_set[bi]) && (ofs_set[oi] & 'hFF) == 'hAA)
                              ? "R2 compat addr" : "R1 addr",
                              64'(bus_addr), 64'(exp_addr(ofs_set[oi], bus_set[bi], ilv_set[ii], dw)));
                        // R4 R5 R6 data
                        check(be ? "R5 R6 data" : "R4 R6 data", bus_data,
                              exp_data(cmd_byte, bus_set[bi], ilv_set[ii], be[0]));
                        // R7 R8 status
                        check(be ? "R8 status" : "R7 status", 64'(stat_merged),
                              64'(exp_stat(stat_word, bus_set[bi], ilv_set[ii], be[0])));
                    end else begin
                        check("R3 zero data", bus_data, 64'd0);
                        check("R3 zero addr", 64'(bus_addr), 64'd0);
                        check("R3 zero stat", 64'(stat_merged), 64'd0);
                    end
                end
        // R9 valid drops one cycle after request drops
        req_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R9 valid drop", 64'(out_valid), 64'd0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule